// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Port

This block models the digital side of one analog-to-digital converter running in its daisy-chain readout mode, for use as a cascadable target when exercising a host controller. The host raises the convert pin while the serial clock is low. The model then waits a fixed number of system clock cycles that stand in for the conversion. When that wait ends, it copies a parallel sample word into its result register and presents the most significant bit on its serial output.

Each later falling edge of the serial clock moves the register one place toward the output and takes in the serial input at the far end. When several copies are wired output to input, the device closest to the host sends its own word first, and the words of the devices further up the chain follow on the same wire. Every pin is sampled by the system clock, so the host's serial clock must be much slower than that clock. A serial clock edge that comes in during the conversion wait is ignored and raises a one-cycle error pulse. Dropping convert ends a readback, and a fresh rising edge starts a new conversion.

Top module: `chain_adc_port`

## Requirements
- R1: Whenever convert was sampled low at a system clock edge, data-out is low after that edge, whatever the value of data-in.
- R2: A rising convert edge sampled while the serial clock is low starts a conversion. A rising convert edge sampled while the serial clock is high leaves the port idle: data-out stays low and later serial clock edges have no effect until convert drops and rises again.
- R3: Call E the system clock edge that first samples convert high. Data-out shows the result MSB from edge E + CONV_CYCLES onward, and stays low before that edge.
- R4: The result is the DATA_W-bit value on sample_in at the edge that ends the conversion, sent MSB first (bit DATA_W-1 first, bit 0 last).
- R5: A serial clock fall is a system clock edge that samples the serial clock low when the edge before it sampled it high. During readback, each fall puts the next lower result bit on data-out after that edge, and data-out holds its value between falls.
- R6: On each fall during readback, data-in enters the least significant end of the register. After DATA_W falls, data-out therefore carries the upstream device's bits, MSB first, and after 2*DATA_W falls in a two-device chain it carries the data-in of the far device.
- R7: A serial clock fall during a conversion does not shift or change the result. proto_err is high for exactly the one cycle after that edge, and is low at all other times.
- R8: Taking convert low ends a readback that is under way. The next rising convert edge runs a full new conversion and loads a new sample, whose MSB and following bits are then read out.
- R9: During reset and right after it, data-out and proto_err are low and the port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv | input | 1 | Convert pin; the rising edge starts a conversion, and the pin is held high through readback |
| sclk | input | 1 | Serial clock from the host; falling edges shift the register |
| sdi | input | 1 | Serial input from the upstream device (or tied low at the chain end) |
| sample_in | input | DATA_W | Parallel sample captured when the conversion completes |
| sdo | output | 1 | Serial output toward the host or the next device |
| proto_err | output | 1 | One-cycle pulse on a serial clock fall during a conversion |

## Verification
All outputs come from registers that are updated at the system clock edge that samples the stimulus. The bench changes inputs just after a falling clock edge and reads outputs at the next falling edge, which is half a cycle after that decisive rising edge. A serial clock fall therefore shows on data-out, and a protocol error on proto_err, at the first sample after the host lowers the serial clock. The result MSB is due at the (CONV_CYCLES+1)-th sample after convert rises, and the bench also checks the sample just before it to confirm the conversion delay is exact. The length of each conversion is also checked by a cycle counter in the checker instead of a deep $past.

// File: rtl/chain_adc_pkg.sv
// Package: shared types for the chainable converter serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package chain_adc_pkg;

    // Port phase: idle, waiting out the conversion, or shifting a result.
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_CONV = 2'd1,
        CAP_READ = 2'd2
    } cap_state_e;

endpackage

// File: rtl/cap_edge_detect.sv
// Module: cap_edge_detect
// Samples the convert and serial clock pins once per system clock and
// reports a convert rising edge and a serial clock falling edge.
// Assumes: both pins are already synchronous to clk and change far
// less often than clk toggles.
module cap_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv,
    input  logic sclk,
    output logic cnv_rise,
    output logic sclk_fall
);

    logic cnv_q;
    logic sclk_q;

    // Keep last cycle's pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_q  <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            cnv_q  <= cnv;
            sclk_q <= sclk;
        end
    end

    // Edge decode against the previous levels.
    always_comb begin
        cnv_rise  = cnv & ~cnv_q;
        sclk_fall = ~sclk & sclk_q;
    end

endmodule

// File: rtl/cap_conv_timer.sv
// Module: cap_conv_timer
// Counts out the conversion delay. After a start pulse, done is high
// during the CONV_CYCLES-th following cycle. abort clears it at once.
// Assumes: CONV_CYCLES >= 1.
module cap_conv_timer #(
    parameter int CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);

    localparam int CW = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] remain_q;
    logic          running_q;

    // Load, count down, and stop on abort or on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (abort) begin
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (start) begin
            remain_q  <= LOAD_VAL;
            running_q <= 1'b1;
        end else if (running_q) begin
            if (remain_q == '0) begin
                running_q <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Completion flag for the final counted cycle.
    always_comb begin
        done = running_q && (remain_q == '0);
    end

endmodule

// File: rtl/cap_shift_reg.sv
// Module: cap_shift_reg
// Result register that also serves as a pass-through stage: it loads a
// parallel word and shifts it MSB first, filling from the serial input.
// Assumes: load and shift are never high together.
module cap_shift_reg #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word,
    output logic              msb
);

    logic [DATA_W-1:0] reg_q;

    // Parallel load or a one-place shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (load) begin
            reg_q <= load_word;
        end else if (shift) begin
            reg_q <= {reg_q[DATA_W-2:0], ser_in};
        end
    end

    // Expose the word and the bit driven toward the output.
    always_comb begin
        word = reg_q;
        msb  = reg_q[DATA_W-1];
    end

endmodule

// File: rtl/chain_adc_port.sv
// Module: chain_adc_port (top)
// Digital serial port of one converter in daisy-chain readout. A convert
// rise with the serial clock low starts a timed conversion. At its end
// the sample is loaded and its MSB is driven out. Serial clock falls then
// shift the result out while upstream data enters behind it.
// Assumes: every pin is synchronous to clk; sclk is slow next to clk.
module chain_adc_port #(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              proto_err
);

    import chain_adc_pkg::*;

    cap_state_e        st;
    logic              cnv_rise;
    logic              sclk_fall;
    logic              conv_done;
    logic              conv_start;
    logic              do_load;
    logic              do_shift;
    logic              shreg_msb;
    logic [DATA_W-1:0] shreg_q;

    cap_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv       (cnv),
        .sclk      (sclk),
        .cnv_rise  (cnv_rise),
        .sclk_fall (sclk_fall)
    );

    cap_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .abort (~cnv),
        .done  (conv_done)
    );

    cap_shift_reg #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_word (sample_in),
        .shift     (do_shift),
        .ser_in    (sdi),
        .word      (shreg_q),
        .msb       (shreg_msb)
    );

    // Decode start, load and shift strobes from the phase and edges.
    always_comb begin
        conv_start = (st == CAP_IDLE) && cnv && cnv_rise && !sclk;
        do_load    = (st == CAP_CONV) && cnv && conv_done;
        do_shift   = (st == CAP_READ) && cnv && sclk_fall;
    end

    // Phase sequencer: convert low always returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= CAP_IDLE;
        end else if (!cnv) begin
            st <= CAP_IDLE;
        end else begin
            case (st)
                CAP_IDLE: if (conv_start) st <= CAP_CONV;
                CAP_CONV: if (conv_done)  st <= CAP_READ;
                CAP_READ: st <= CAP_READ;
                default:  st <= CAP_IDLE;
            endcase
        end
    end

    // Flag a serial clock fall that lands inside a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= (st == CAP_CONV) && cnv && sclk_fall;
        end
    end

    // Output drive: the register MSB only during readback.
    always_comb begin
        sdo = (st == CAP_READ) ? shreg_msb : 1'b0;
    end

endmodule

// File: rtl/chain_adc_port_chk.sv
// Module: chain_adc_port_chk
// Property checker bound into every chain_adc_port instance.
// Assumes: reset is asserted during the first clock edges of a run.
module chain_adc_port_chk
    import chain_adc_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sdo,
    input  logic              proto_err,
    input  cap_state_e        st,
    input  logic [DATA_W-1:0] shreg
);

    int conv_len;

    // Count edges spent converting, to check the delay window.
    always_ff @(posedge clk) begin
        if (!rst_n || st != CAP_CONV) begin
            conv_len <= 0;
        end else begin
            conv_len <= conv_len + 1;
        end
    end

    // R1: convert low last edge means output low now.
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnv) |-> !sdo);

    // R2: a rise seen with the serial clock high leaves the port idle.
    a_r2_no_start_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == CAP_IDLE && $past(cnv) && !$past(cnv, 2) && $past(sclk))
        |-> st == CAP_IDLE);

    // R3: readback begins after exactly CONV_CYCLES converting edges.
    a_r3_conv_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ && $past(st) == CAP_CONV) |-> conv_len == CONV_CYCLES);

    // R4: first output bit is the MSB of the sample at completion.
    a_r4_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ && $past(st) == CAP_CONV)
        |-> sdo == $past(sample_in[DATA_W-1]));

    // R5: each serial fall in readback advances to the next bit.
    a_r5_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ && $past(st) == CAP_READ && $past(sclk, 2) && !$past(sclk))
        |-> sdo == $past(shreg[DATA_W-2]));

    // R5: without a fall the output bit holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ && $past(st) == CAP_READ && !($past(sclk, 2) && !$past(sclk)))
        |-> sdo == $past(sdo));

    // R7: the error pulse only follows a converting cycle.
    a_r7_err_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(st) == CAP_CONV);

    // R7: the error pulse lasts a single cycle.
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

endmodule

bind chain_adc_port chain_adc_port_chk #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv       (cnv),
    .sclk      (sclk),
    .sample_in (sample_in),
    .sdo       (sdo),
    .proto_err (proto_err),
    .st        (st),
    .shreg     (shreg_q)
);

// File: tb/sim_chain_adc_port.sv
// Bench: two-device chain. u1 is upstream and feeds u0, and the host reads u0.
// Inputs change after a falling clk edge; outputs are read at the next one.
module sim_chain_adc_port;

    localparam int DW   = 18;
    localparam int CONV = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnv;
    logic          sclk;
    logic          sdi_far;
    logic [DW-1:0] samp_a;
    logic [DW-1:0] samp_b;
    logic          sdo;
    logic          sdo_up;
    logic          err0;
    logic          err1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sclk(sclk), .sdi(sdo_up),
        .sample_in(samp_a), .sdo(sdo), .proto_err(err0)
    );

    chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) u1 (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sclk(sclk), .sdi(sdi_far),
        .sample_in(samp_b), .sdo(sdo_up), .proto_err(err1)
    );

    // Record one comparison and report a mismatch.
    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // One serial clock fall: high for a cycle, then low for a cycle.
    task automatic sclk_fall_once();
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    // Drop convert for a cycle, raise it, and check the exact MSB arrival.
    task automatic start_conv(input string req);
        cnv = 1'b0;
        @(negedge clk);
        cnv = 1'b1;
        repeat (CONV) @(negedge clk);
        chk({req, " R3 early"}, sdo, 1'b0);
        @(negedge clk);
        chk({req, " R3 R4 msb"}, sdo, samp_a[DW-1]);
    endtask

    // R9: reset state.
    task automatic t_reset();
        rst_n = 1'b0; cnv = 1'b0; sclk = 1'b0; sdi_far = 1'b0;
        samp_a = '0; samp_b = '0;
        repeat (3) @(negedge clk);
        chk("R9 sdo", sdo, 1'b0);
        chk("R9 err", err0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sdo after", sdo, 1'b0);
    endtask

    // R1: convert low keeps data-out low with data-in high.
    task automatic t_idle_low();
        sdi_far = 1'b1;
        samp_a = '1; samp_b = '1;
        repeat (2) @(negedge clk);
        chk("R1 sdi high", sdo, 1'b0);
        sclk_fall_once();
        chk("R1 after sclk", sdo, 1'b0);
    endtask

    // R3-R6: full two-device readback, including far-end pass-through.
    task automatic t_chain_read();
        samp_a = 18'h2D3C5; samp_b = 18'h3A61E; sdi_far = 1'b1;
        start_conv("chain");
        for (int i = 0; i < 2 * DW; i++) begin
            if (i < DW) chk("R5 own bit", sdo, samp_a[DW-1-i]);
            else        chk("R6 upstream bit", sdo, samp_b[2*DW-1-i]);
            sclk_fall_once();
        end
        chk("R6 far sdi", sdo, 1'b1);
        repeat (3) @(negedge clk);
        chk("R5 hold", sdo, 1'b1);
        cnv = 1'b0;
        @(negedge clk);
        chk("R1 cnv drop", sdo, 1'b0);
    endtask

    // R2: convert rising with serial clock high leaves the port idle.
    task automatic t_sclk_high_start();
        samp_a = '1; samp_b = '1;
        cnv = 1'b0; sclk = 1'b1;
        @(negedge clk);
        cnv = 1'b1;
        repeat (CONV + 3) @(negedge clk);
        chk("R2 no start", sdo, 1'b0);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 no shift", sdo, 1'b0);
        chk("R2 no err", err0, 1'b0);
        cnv = 1'b0;
        @(negedge clk);
    endtask

    // R7: a fall during conversion flags an error and shifts nothing.
    task automatic t_early_clock();
        samp_a = 18'h20001; samp_b = '0; sdi_far = 1'b0;
        cnv = 1'b0; sclk = 1'b0;
        @(negedge clk);
        cnv = 1'b1;
        @(negedge clk);
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
        chk("R7 err pulse", err0, 1'b1);
        @(negedge clk);
        chk("R7 err clears", err0, 1'b0);
        repeat (CONV + 1 - 4) @(negedge clk);
        chk("R7 msb intact", sdo, 1'b1);
        sclk_fall_once();
        chk("R7 bit16 intact", sdo, 1'b0);
        chk("R7 no err in read", err0, 1'b0);
    endtask

    // R8: convert drop aborts readback; a new rise reloads fresh data.
    task automatic t_abort();
        samp_a = 18'h3FFFF; samp_b = '0;
        start_conv("abort first");
        repeat (3) sclk_fall_once();
        samp_a = 18'h0A5A5;
        start_conv("R8 reload");
        for (int i = 1; i < 6; i++) begin
            sclk_fall_once();
            chk("R8 new bits", sdo, samp_a[DW-1-i]);
        end
        cnv = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle_low();
        t_chain_read();
        t_sclk_high_start();
        t_early_clock();
        t_abort();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule